// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a bank of general-purpose pins and records every change of logic level on the pins that are currently inputs. Each pin owns one sticky status bit. A single interrupt line summarises the status bits that software has chosen to let through, and its active level and its output enable are both programmable. The pin levels arrive already synchronised to the block clock. Register decoding and the serial host link sit elsewhere. They hand this block the configuration masks and a one-cycle read strobe for each status byte.

Detection compares each pin's level with its level in the previous cycle. A pin that is an output, or whose direction is being changed, is excluded from the comparison. The status word is cleared one byte at a time, when the host reads that byte. Because a new change always takes priority over the clear, an event that lands in the same cycle as the read is never lost. The interrupt is combinational from the registered status, so the interrupt line follows the status register with no extra delay.

Top module: `pin_change_irq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `stat_q` reads all zeros.
- R2: A 0-to-1 change on a pin whose `pin_dir` bit is 0 (0 = input) sets the matching `stat_q` bit after the next rising clock edge.
- R3: A 1-to-0 change on an input pin sets its `stat_q` bit in the same way.
- R4: A change on a pin whose `pin_dir` bit is 1 (output) never sets its status bit.
- R5: A change in the same cycle as that pin's `pin_dir` bit changes value does not set status, in either direction of the change.
- R6: A status bit sets whether or not its `irq_mask` bit is 1.
- R7: A pulse on `stat_rd[b]` clears status bits `[8b+7:8b]` (byte 0 is bits 7..0, byte 1 is bits 15..8) at the next edge. The other byte is left unchanged, and set bits stay set until they are read.
- R8: A change that occurs in the same cycle as the read of its byte leaves that bit set after the clear.
- R9: The interrupt is active when any bit of `stat_q & irq_mask` is 1. With `irq_pol` = 1, `irq_pad` is 1 when active and 0 when idle. With `irq_pol` = 0, `irq_pad` is 0 when active and 1 when idle.
- R10: `irq_oe` equals `irq_en`, so 0 releases the line. Status bits keep latching while `irq_en` is 0.
- R11: The pin levels present when reset is released are taken as the baseline and set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | 16 | Synchronised pin levels |
| pin_dir | input | 16 | Direction per pin, 1 = output |
| irq_mask | input | 16 | Per-pin interrupt enable |
| irq_en | input | 1 | Global interrupt output enable |
| irq_pol | input | 1 | Interrupt active level, 1 = high |
| stat_rd | input | 2 | Read strobe, one per status byte |
| stat_q | output | 16 | Latched change status |
| irq_pad | output | 1 | Interrupt line value |
| irq_oe | output | 1 | Interrupt line output enable |

## Verification
The hardest case to reach from the ports is one where three things share a single edge: a pin change, a read strobe on the same byte, and a second already-set bit in that byte. The stimulus sets one bit, then toggles a neighbouring pin in exactly the cycle of the read. This shows the old bit cleared and the new one kept. A similar step flips a pin's direction and its level together, and then toggles the pin again one cycle later. This separates the excluded cycle from normal detection.

// File: rtl/pcic_pkg.sv
package pcic_pkg;

    localparam int unsigned PIN_COUNT  = 16;
    localparam int unsigned BYTE_WIDTH = 8;

    typedef enum logic {
        IRQ_ACT_LOW  = 1'b0,
        IRQ_ACT_HIGH = 1'b1
    } irq_pol_e;

    typedef struct packed {
        logic     drive_en;
        irq_pol_e pol;
    } irq_ctrl_t;

    // Map "interrupt active" onto the line level for the chosen polarity.
    function automatic logic line_level(irq_pol_e pol, logic active);
        return (pol == IRQ_ACT_HIGH) ? active : ~active;
    endfunction

endpackage

// File: rtl/pcic_edge_det.sv
module pcic_edge_det #(
    parameter int unsigned W = pcic_pkg::PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dir,
    output logic [W-1:0] chg
);
    logic [W-1:0] lvl_q;
    logic [W-1:0] dir_q;
    logic         armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= '0;
            dir_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            lvl_q   <= lvl;
            dir_q   <= dir;
            armed_q <= 1'b1;
        end
    end

    // A pin counts only if it was an input in both this cycle and the last one.
    always_comb begin
        chg = '0;
        if (armed_q) chg = (lvl ^ lvl_q) & ~dir & ~dir_q;
    end
endmodule

// File: rtl/pcic_status.sv
module pcic_status #(
    parameter int unsigned W  = pcic_pkg::PIN_COUNT,
    parameter int unsigned BW = pcic_pkg::BYTE_WIDTH,
    localparam int unsigned NB = (W + BW - 1) / BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  chg,
    input  logic [NB-1:0] rd,
    output logic [W-1:0]  stat
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) stat[i] <= 1'b0;
            else     stat[i] <= (stat[i] & ~rd[i / BW]) | chg[i];
        end
    end
endmodule

// File: rtl/pcic_irq_out.sv
module pcic_irq_out #(
    parameter int unsigned W = pcic_pkg::PIN_COUNT
) (
    input  logic                stat,
    input  logic [W-1:0]        stat_vec,
    input  logic [W-1:0]        mask,
    input  pcic_pkg::irq_ctrl_t ctrl,
    output logic                pad,
    output logic                oe
);
    logic hit;

    always_comb begin
        hit = |(stat_vec & mask) & stat;
        pad = pcic_pkg::line_level(ctrl.pol, hit);
        oe  = ctrl.drive_en;
    end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
    parameter int unsigned NUM_PINS = pcic_pkg::PIN_COUNT,
    parameter int unsigned BYTE_W   = pcic_pkg::BYTE_WIDTH,
    localparam int unsigned NUM_BYTES = (NUM_PINS + BYTE_W - 1) / BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  pin_lvl,
    input  logic [NUM_PINS-1:0]  pin_dir,
    input  logic [NUM_PINS-1:0]  irq_mask,
    input  logic                 irq_en,
    input  logic                 irq_pol,
    input  logic [NUM_BYTES-1:0] stat_rd,
    output logic [NUM_PINS-1:0]  stat_q,
    output logic                 irq_pad,
    output logic                 irq_oe
);
    logic [NUM_PINS-1:0] chg;
    pcic_pkg::irq_ctrl_t ctrl;

    assign ctrl.drive_en = irq_en;
    assign ctrl.pol      = pcic_pkg::irq_pol_e'(irq_pol);

    pcic_edge_det #(.W(NUM_PINS)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (pin_lvl),
        .dir (pin_dir),
        .chg (chg)
    );

    pcic_status #(.W(NUM_PINS), .BW(BYTE_W)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .chg  (chg),
        .rd   (stat_rd),
        .stat (stat_q)
    );

    pcic_irq_out #(.W(NUM_PINS)) u_irq (
        .stat     (1'b1),
        .stat_vec (stat_q),
        .mask     (irq_mask),
        .ctrl     (ctrl),
        .pad      (irq_pad),
        .oe       (irq_oe)
    );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
    parameter int unsigned W  = 16,
    parameter int unsigned BW = 8,
    localparam int unsigned NB = (W + BW - 1) / BW
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  pin_lvl,
    input logic [W-1:0]  pin_dir,
    input logic [W-1:0]  irq_mask,
    input logic          irq_pol,
    input logic [NB-1:0] stat_rd,
    input logic [W-1:0]  stat_q,
    input logic          irq_pad
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (stat_q == '0));

    // R4: newly set bits only on pins that were inputs
    a_r4_no_set_on_output: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0) |-> ((stat_q & ~$past(stat_q) & $past(pin_dir)) == '0));

    // R2 / R3: newly set bits need a level change on that pin
    a_r2_set_needs_change: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |->
        ((stat_q & ~$past(stat_q) & ~($past(pin_lvl) ^ $past(pin_lvl, 2))) == '0));

    // R7: set bits persist without a read of their byte
    for (genvar i = 0; i < W; i++) begin : g_sticky
        a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
            (since_rst != 2'd0) && $past(stat_q[i]) && !$past(stat_rd[i / BW]) |-> stat_q[i]);
    end

    // R9
    a_r9_active_level: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & irq_mask) != '0) |-> (irq_pad == irq_pol));
    a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & irq_mask) == '0) |-> (irq_pad != irq_pol));
endmodule

bind pin_change_irq pin_change_irq_chk #(.W(NUM_PINS), .BW(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_lvl  (pin_lvl),
    .pin_dir  (pin_dir),
    .irq_mask (irq_mask),
    .irq_pol  (irq_pol),
    .stat_rd  (stat_rd),
    .stat_q   (stat_q),
    .irq_pad  (irq_pad)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int BW = 8;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_lvl, pin_dir, irq_mask;
    logic          irq_en, irq_pol;
    logic [NB-1:0] stat_rd;
    logic [NP-1:0] stat_q;
    logic          irq_pad, irq_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pin_change_irq u_dut (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .pin_dir(pin_dir),
        .irq_mask(irq_mask), .irq_en(irq_en), .irq_pol(irq_pol),
        .stat_rd(stat_rd), .stat_q(stat_q), .irq_pad(irq_pad), .irq_oe(irq_oe)
    );

    int    total = 0;
    int    bad   = 0;
    string req   = "R1";

    // behavioural reference state
    bit [NP-1:0] m_stat, m_lvl, m_dir;
    bit          m_arm;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit [NP-1:0] nxt;
        if (rst) begin
            m_stat = '0; m_lvl = '0; m_dir = '0; m_arm = 0;
        end else begin
            nxt = m_stat;
            for (int i = 0; i < NP; i++) begin
                if (stat_rd[i / BW]) nxt[i] = 1'b0;
                if (m_arm && pin_lvl[i] != m_lvl[i] && !pin_dir[i] && !m_dir[i])
                    nxt[i] = 1'b1;
            end
            m_stat = nxt;
            m_lvl  = pin_lvl;
            m_dir  = pin_dir;
            m_arm  = 1;
        end
    endtask

    task automatic compare();
        bit any;
        any = (m_stat & irq_mask) != '0;
        chk(req, "stat_q", 32'(stat_q), 32'(m_stat));
        chk(req, "irq_oe", 32'(irq_oe), 32'(irq_en));
        chk(req, "irq_pad", 32'(irq_pad), 32'(irq_pol ? any : !any));
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        rst = 1; pin_lvl = 16'hA5A5; pin_dir = '0; irq_mask = '0;
        irq_en = 0; irq_pol = 0; stat_rd = '0;
        req = "R1"; tick(3);
        chk("R1", "reset stat", 32'(stat_q), 0);

        rst = 0; req = "R11"; tick(2);
        chk("R11", "baseline stat", 32'(stat_q), 0);

        req = "R2"; pin_lvl[3] = 1'b1; tick();
        chk("R2", "rise bit3", 32'(stat_q[3]), 1);

        req = "R7"; stat_rd = 2'b11; tick(); stat_rd = '0;
        chk("R7", "clear both", 32'(stat_q), 0);

        req = "R3"; pin_lvl[0] = 1'b0; tick();
        chk("R3", "fall bit0", 32'(stat_q[0]), 1);
        chk("R6", "set with mask 0", 32'(stat_q[0]), 1);

        req = "R4"; pin_dir[5] = 1'b1; tick();
        pin_lvl[5] = ~pin_lvl[5]; tick(2);
        chk("R4", "output pin", 32'(stat_q[5]), 0);

        req = "R5"; pin_dir[6] = 1'b1; tick();
        pin_dir[6] = 1'b0; pin_lvl[6] = ~pin_lvl[6]; tick();
        chk("R5", "dir change cycle", 32'(stat_q[6]), 0);
        pin_lvl[6] = ~pin_lvl[6]; tick();
        chk("R5", "after dir change", 32'(stat_q[6]), 1);
        pin_dir[7] = 1'b0; pin_dir[8] = 1'b1; tick();
        pin_dir[8] = 1'b0; pin_lvl[8] = ~pin_lvl[8]; tick();
        chk("R5", "out to in", 32'(stat_q[8]), 0);

        req = "R7"; pin_lvl[12] = ~pin_lvl[12]; tick();
        stat_rd = 2'b01; tick(); stat_rd = '0;
        chk("R7", "low byte only", 32'(stat_q), 32'h1000);

        req = "R8"; pin_lvl[4] = ~pin_lvl[4]; tick();
        stat_rd = 2'b01; pin_lvl[2] = ~pin_lvl[2]; tick(); stat_rd = '0;
        chk("R8", "kept bit2", 32'(stat_q[2]), 1);
        chk("R8", "cleared bit4", 32'(stat_q[4]), 0);

        req = "R9"; irq_en = 1; irq_pol = 1; irq_mask = 16'h0004; tick();
        chk("R9", "hi active", 32'(irq_pad), 1);
        irq_mask = 16'h0010; tick();
        chk("R9", "hi idle", 32'(irq_pad), 0);
        irq_pol = 0; tick();
        chk("R9", "lo idle", 32'(irq_pad), 1);
        irq_mask = 16'h1000; tick();
        chk("R9", "lo active", 32'(irq_pad), 0);

        req = "R10"; irq_en = 0; tick();
        chk("R10", "released", 32'(irq_oe), 0);
        pin_lvl[9] = ~pin_lvl[9]; tick();
        chk("R10", "latch while off", 32'(stat_q[9]), 1);

        req = "R9"; irq_en = 1; seed = 32'h1357;
        for (int n = 0; n < 300; n++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            pin_lvl  = pin_lvl ^ (16'(seed) & 16'(seed >> 7));
            if (seed[20:18] == 3'd0) pin_dir = 16'(seed >> 3) & 16'h0F0F;
            if (seed[23:21] == 3'd1) irq_mask = 16'(seed >> 9);
            irq_pol = seed[27];
            stat_rd = (seed[30:28] == 3'd2) ? 2'(seed >> 11) : 2'b00;
            tick();
        end
        stat_rd = '0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule